// File: doc/BRIEF.md
# Configurable-Frame Serial Byte Transceiver

This block moves bytes over a single-wire asynchronous serial link, one wire for each direction. The transmit half takes a byte on a valid/ready stream and shifts it out as a frame. The frame is a low start bit, eight data bits least significant first, an optional parity bit, and one or two high stop bits. The receive half watches the incoming line and finds each start bit. It reads every later bit at its midpoint and returns the byte together with a parity-error flag and a framing-error flag.

The block has no baud generator of its own. Two strobes from outside set all bit timing. `bit_tick` pulses once for every bit period and marks the bit boundaries used by the transmitter. `mid_tick` pulses once for every bit period, half a period after `bit_tick`, and marks the receiver's sampling points. Three plain configuration pins choose the frame: two transmit stop bits, parity on, and odd parity. Parity on and odd parity apply to both directions. Two stop bits applies to transmit only, because the receiver checks a single stop bit. The configuration is captured at the start of each frame, so a change takes effect only on the next frame.

On the stream input, a byte is taken on any clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` stays low from that edge until the last stop bit of the frame has ended. While `tx_ready` is low, the source must hold its byte and wait. The receive output has no back-pressure: each byte is shown for exactly one cycle.

Top module: `uart_xcvr`

## Requirements
- R1: After reset, `txd` is high, `tx_ready` is high, and `rx_valid`, `rx_par_err` and `rx_frm_err` are low.
- R2: A transmitted frame begins with a low start bit, followed by the eight data bits least significant first. Every bit lasts exactly one `bit_tick` period, and `txd` changes only on an edge where `bit_tick` is high.
- R3: When `cfg_two_stop` is 0 the frame ends with one high stop bit; when it is 1 the frame ends with two. `tx_ready` rises exactly (1 + 8 + parity + stop) bit periods after `txd` falls for the start bit.
- R4: When `cfg_par_en` is 1, every frame in both directions carries one parity bit between the last data bit and the stop bit. When it is 0, no frame carries one.
- R5: The parity bit is the XOR of the eight data bits when `cfg_par_odd` is 0, and the inverse of that value when `cfg_par_odd` is 1. `cfg_par_odd` has no effect while `cfg_par_en` is 0.
- R6: A byte is accepted on an edge where `tx_valid` and `tx_ready` are both high. `tx_ready` is low on the next cycle and stays low until that frame is complete, so a byte held on the input during that time is sent only after the current frame.
- R7: The receiver reads each bit on a `mid_tick`. It presents `rx_data` with a `rx_valid` pulse one cycle long, in the cycle after the `mid_tick` on which the stop bit is read.
- R8: The receiver checks exactly one stop bit whatever `cfg_two_stop` is set to. A new start bit that follows a single stop bit directly is received correctly.
- R9: `rx_par_err` is high with `rx_valid` when parity is on and the received parity bit does not match the value given by R5.
- R10: `rx_frm_err` is high with `rx_valid` when the stop bit is read low. Both flags may be high for the same byte.
- R11: A falling edge on `rxd` is confirmed at the next `mid_tick`. If the line is high again at that point, no byte is delivered and the receiver waits for the next falling edge.
- R12: `rx_par_err` and `rx_frm_err` are low in every cycle where `rx_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe at each bit boundary |
| mid_tick | input | 1 | One-cycle strobe at each bit midpoint |
| cfg_two_stop | input | 1 | Transmit two stop bits when 1 |
| cfg_par_en | input | 1 | Parity bit present when 1 |
| cfg_par_odd | input | 1 | Odd parity when 1, even parity when 0 |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | `tx_data` is valid |
| tx_ready | output | 1 | Transmitter can take a byte |
| txd | output | 1 | Serial output, high when idle |
| rxd | input | 1 | Serial input, asynchronous |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse when a byte is delivered |
| rx_par_err | output | 1 | Parity mismatch on the delivered byte |
| rx_frm_err | output | 1 | Stop bit read low on the delivered byte |

## Verification
The transmitter is tried in loopback with all three settings of the stop and parity controls. Patterns of all zeros and all ones separate the even and odd parity values, and patterns with alternating bits expose a reversed bit order. The measured frame length tells one stop bit from two and shows whether a parity bit is present. Two bytes sent with `tx_valid` held high test back-pressure. The receiver is driven directly with:
- frames that are correct, and frames separated by only one stop bit;
- a frame with the parity bit flipped, a frame with a low stop bit, and a frame with both faults, which separate the two error flags;
- a short low pulse, which must not be taken for a start bit.

// File: rtl/uart_xcvr_pkg.sv
package uart_xcvr_pkg;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_LOAD,
    TX_START,
    TX_DATA,
    TX_PAR,
    TX_STOP
  } tx_state_e;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_CONFIRM,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

  typedef struct packed {
    logic two_stop;
    logic par_en;
    logic par_odd;
  } frame_cfg_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= d_async;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path
  import uart_xcvr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  frame_cfg_t        cfg,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              txd
);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  tx_state_e         state_q;
  logic [DATA_W-1:0] shift_q;
  logic [IDX_W-1:0]  idx_q;
  frame_cfg_t        cfg_q;
  logic              par_q;
  logic              stop_more_q;
  logic              txd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= TX_IDLE;
      shift_q     <= '0;
      idx_q       <= '0;
      cfg_q       <= '0;
      par_q       <= 1'b0;
      stop_more_q <= 1'b0;
      txd_q       <= 1'b1;
    end else begin
      case (state_q)
        TX_IDLE: begin
          txd_q <= 1'b1;
          if (in_valid) begin
            shift_q <= in_data;
            cfg_q   <= cfg;
            par_q   <= (^in_data) ^ cfg.par_odd;
            state_q <= TX_LOAD;
          end
        end
        TX_LOAD: begin
          if (bit_tick) begin
            txd_q   <= 1'b0;
            state_q <= TX_START;
          end
        end
        TX_START: begin
          if (bit_tick) begin
            txd_q   <= shift_q[0];
            idx_q   <= '0;
            state_q <= TX_DATA;
          end
        end
        TX_DATA: begin
          if (bit_tick) begin
            if (idx_q == LAST_IDX) begin
              if (cfg_q.par_en) begin
                txd_q   <= par_q;
                state_q <= TX_PAR;
              end else begin
                txd_q       <= 1'b1;
                stop_more_q <= cfg_q.two_stop;
                state_q     <= TX_STOP;
              end
            end else begin
              shift_q <= shift_q >> 1;
              txd_q   <= shift_q[1];
              idx_q   <= idx_q + 1'b1;
            end
          end
        end
        TX_PAR: begin
          if (bit_tick) begin
            txd_q       <= 1'b1;
            stop_more_q <= cfg_q.two_stop;
            state_q     <= TX_STOP;
          end
        end
        TX_STOP: begin
          if (bit_tick) begin
            if (stop_more_q) stop_more_q <= 1'b0;
            else             state_q     <= TX_IDLE;
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  assign in_ready = (state_q == TX_IDLE);
  assign txd      = txd_q;
endmodule

// File: rtl/uart_rx_path.sv
module uart_rx_path
  import uart_xcvr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mid_tick,
  input  frame_cfg_t        cfg,
  input  logic              line,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_par_err,
  output logic              out_frm_err
);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  rx_state_e         state_q;
  logic [DATA_W-1:0] shift_q;
  logic [IDX_W-1:0]  idx_q;
  frame_cfg_t        cfg_q;
  logic              line_prev_q;
  logic              perr_q;
  logic [DATA_W-1:0] data_q;
  logic              valid_q;
  logic              perr_out_q;
  logic              ferr_out_q;
  logic              fall;

  assign fall = line_prev_q & ~line;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= RX_IDLE;
      shift_q     <= '0;
      idx_q       <= '0;
      cfg_q       <= '0;
      line_prev_q <= 1'b1;
      perr_q      <= 1'b0;
      data_q      <= '0;
      valid_q     <= 1'b0;
      perr_out_q  <= 1'b0;
      ferr_out_q  <= 1'b0;
    end else begin
      line_prev_q <= line;
      valid_q     <= 1'b0;
      perr_out_q  <= 1'b0;
      ferr_out_q  <= 1'b0;
      case (state_q)
        RX_IDLE: begin
          if (fall) state_q <= RX_CONFIRM;
        end
        RX_CONFIRM: begin
          if (mid_tick) begin
            if (!line) begin
              cfg_q   <= cfg;
              idx_q   <= '0;
              perr_q  <= 1'b0;
              state_q <= RX_DATA;
            end else begin
              state_q <= RX_IDLE;
            end
          end
        end
        RX_DATA: begin
          if (mid_tick) begin
            shift_q <= {line, shift_q[DATA_W-1:1]};
            idx_q   <= idx_q + 1'b1;
            if (idx_q == LAST_IDX) begin
              state_q <= cfg_q.par_en ? RX_PAR : RX_STOP;
            end
          end
        end
        RX_PAR: begin
          if (mid_tick) begin
            perr_q  <= line ^ (^shift_q) ^ cfg_q.par_odd;
            state_q <= RX_STOP;
          end
        end
        RX_STOP: begin
          if (mid_tick) begin
            data_q     <= shift_q;
            valid_q    <= 1'b1;
            perr_out_q <= cfg_q.par_en & perr_q;
            ferr_out_q <= ~line;
            state_q    <= RX_IDLE;
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign out_data    = data_q;
  assign out_valid   = valid_q;
  assign out_par_err = perr_out_q;
  assign out_frm_err = ferr_out_q;
endmodule

// File: rtl/uart_xcvr.sv
module uart_xcvr
  import uart_xcvr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              mid_tick,
  input  logic              cfg_two_stop,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              txd,
  input  logic              rxd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_par_err,
  output logic              rx_frm_err
);
  frame_cfg_t cfg;
  logic       rxd_s;

  assign cfg.two_stop = cfg_two_stop;
  assign cfg.par_en   = cfg_par_en;
  assign cfg.par_odd  = cfg_par_odd;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (rxd),
    .d_sync  (rxd_s)
  );

  uart_tx_path #(.DATA_W(DATA_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .cfg      (cfg),
    .in_data  (tx_data),
    .in_valid (tx_valid),
    .in_ready (tx_ready),
    .txd      (txd)
  );

  uart_rx_path #(.DATA_W(DATA_W)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .mid_tick    (mid_tick),
    .cfg         (cfg),
    .line        (rxd_s),
    .out_data    (rx_data),
    .out_valid   (rx_valid),
    .out_par_err (rx_par_err),
    .out_frm_err (rx_frm_err)
  );
endmodule

// File: rtl/uart_xcvr_chk.sv
module uart_xcvr_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic mid_tick,
  input logic cfg_par_en,
  input logic tx_valid,
  input logic tx_ready,
  input logic txd,
  input logic rx_valid,
  input logic rx_par_err,
  input logic rx_frm_err
);
  // R1: an idle transmitter holds the line high
  a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> txd);

  // R2: the serial output moves only on a bit boundary
  a_r2_txd_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (txd != $past(txd)) |-> $past(bit_tick));

  // R6: after a handshake the transmitter is busy
  a_r6_ready_drops_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  // R7: delivery pulse is one cycle long
  a_r7_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R7: delivery follows a midpoint sample
  a_r7_valid_after_mid: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(mid_tick));

  // R12: error flags never appear without a delivery
  a_r12_flags_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> (!rx_par_err && !rx_frm_err));

  // R5: no parity error while parity is disabled throughout the frame tail
  a_r5_no_perr_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !cfg_par_en && !$past(cfg_par_en)) |-> !rx_par_err);
endmodule

bind uart_xcvr uart_xcvr_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_tick   (bit_tick),
  .mid_tick   (mid_tick),
  .cfg_par_en (cfg_par_en),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .txd        (txd),
  .rx_valid   (rx_valid),
  .rx_par_err (rx_par_err),
  .rx_frm_err (rx_frm_err)
);

// File: tb/tb_uart_xcvr.sv
`timescale 1ns/1ps
module tb_uart_xcvr;
  localparam int BIT_CYC = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_two_stop = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_ready, txd, rxd, rx_valid, rx_par_err, rx_frm_err;
  logic [7:0] rx_data;
  logic       loop_en = 1'b1;
  logic       rxd_drv = 1'b1;
  int         phase = 0;
  int         cyc = 0;
  int         n_vec = 0;
  int         n_bad = 0;
  int         n_rx_seen = 0;
  logic       bit_tick, mid_tick;

  logic [10:0] txq[$];  // {two_stop, par_en, par_odd, data}
  logic [9:0]  rxq[$];  // {par_err, frm_err, data}

  always #10 clk = ~clk;
  always @(posedge clk) begin
    phase <= (phase == BIT_CYC - 1) ? 0 : phase + 1;
    cyc   <= cyc + 1;
  end
  assign bit_tick = (phase == 0);
  assign mid_tick = (phase == BIT_CYC / 2);
  assign rxd = loop_en ? txd : rxd_drv;

  uart_xcvr dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .mid_tick(mid_tick),
    .cfg_two_stop(cfg_two_stop), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
    .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err)
  );

  task automatic check(input logic ok, input string req, input int act, input int expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic wait_bit();
    @(negedge clk);
    while (!bit_tick) @(negedge clk);
  endtask

  task automatic wait_mid();
    @(negedge clk);
    while (!mid_tick) @(negedge clk);
  endtask

  // driver: stream a byte into the transmitter, record expectations
  task automatic send_tx(input logic [7:0] b);
    @(negedge clk);
    tx_data  = b;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    txq.push_back({cfg_two_stop, cfg_par_en, cfg_par_odd, b});
    if (loop_en) rxq.push_back({2'b00, b});
    @(negedge clk);
  endtask

  // driver: put a frame directly on the receive line
  task automatic drive_rx(input logic [7:0] b, input logic flip_par, input logic stop_val);
    logic pe, fe;
    pe = cfg_par_en & flip_par;
    fe = ~stop_val;
    rxq.push_back({pe, fe, b});
    wait_bit(); rxd_drv = 1'b0;
    for (int i = 0; i < 8; i++) begin
      wait_bit(); rxd_drv = b[i];
    end
    if (cfg_par_en) begin
      wait_bit(); rxd_drv = (^b) ^ cfg_par_odd ^ flip_par;
    end
    wait_bit(); rxd_drv = stop_val;
  endtask

  task automatic wait_quiet();
    while (!(tx_ready && txq.size() == 0 && rxq.size() == 0)) @(negedge clk);
    repeat (2) wait_bit();
  endtask

  // monitor: receive side scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (!rx_valid && (rx_par_err || rx_frm_err))
        check(1'b0, "R12 flags without valid", {rx_par_err, rx_frm_err}, 0);
      if (rx_valid) begin
        n_rx_seen++;
        if (rxq.size() == 0) begin
          check(1'b0, "R11/R7 unexpected delivery", rx_data, 0);
        end else begin
          logic [9:0] e;
          e = rxq.pop_front();
          check(rx_data == e[7:0], "R7 rx data", rx_data, e[7:0]);
          check(rx_par_err == e[9], "R9 parity flag", rx_par_err, e[9]);
          check(rx_frm_err == e[8], "R10 framing flag", rx_frm_err, e[8]);
        end
      end
    end
  end

  // monitor: transmit side frame decoder
  initial begin : tx_mon
    forever begin
      @(negedge clk);
      if (rst_n && !txd && !tx_ready) begin
        logic [10:0] te;
        int t0, nb;
        t0 = cyc;
        if (txq.size() == 0) begin
          check(1'b0, "R6 unexpected frame", 0, 1);
          te = '0;
        end else begin
          te = txq.pop_front();
        end
        nb = 1 + 8 + int'(te[9]) + (te[10] ? 2 : 1);
        wait_mid();
        check(txd == 1'b0, "R2 start bit", txd, 0);
        for (int i = 0; i < 8; i++) begin
          wait_mid();
          check(txd == te[i], "R2 data bit", txd, te[i]);
        end
        if (te[9]) begin
          wait_mid();
          check(txd == ((^te[7:0]) ^ te[8]), "R5 parity bit", txd, (^te[7:0]) ^ te[8]);
        end
        wait_mid();
        check(txd == 1'b1, "R3 first stop bit", txd, 1);
        if (te[10]) begin
          wait_mid();
          check(txd == 1'b1 && !tx_ready, "R3 second stop bit", {txd, tx_ready}, 2);
        end
        while (!tx_ready) @(negedge clk);
        check((cyc - t0) == nb * BIT_CYC, "R3/R4 frame length", cyc - t0, nb * BIT_CYC);
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : stim
    int seen0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(txd && tx_ready && !rx_valid && !rx_par_err && !rx_frm_err,
          "R1 reset state", {txd, tx_ready, rx_valid, rx_par_err, rx_frm_err}, 5'b11000);

    // loopback: no parity, one stop
    loop_en = 1'b1;
    send_tx(8'hA5); tx_valid = 1'b0;
    wait_quiet();
    // R4 even parity, R3 two stop bits
    cfg_two_stop = 1'b1; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    send_tx(8'h3C); tx_valid = 1'b0;
    wait_quiet();
    // R5 odd parity, R6 back-to-back with valid held
    cfg_par_odd = 1'b1;
    send_tx(8'h81);
    send_tx(8'h00);
    send_tx(8'hFF); tx_valid = 1'b0;
    wait_quiet();
    // R5 odd control ignored when parity off
    cfg_two_stop = 1'b0; cfg_par_en = 1'b0; cfg_par_odd = 1'b1;
    send_tx(8'h5A); tx_valid = 1'b0;
    wait_quiet();

    // direct receive line
    loop_en = 1'b0; rxd_drv = 1'b1;
    repeat (2) wait_bit();
    cfg_two_stop = 1'b1; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    drive_rx(8'h96, 1'b0, 1'b1);
    drive_rx(8'h4B, 1'b0, 1'b1);   // R8 single stop then next start
    wait_bit(); rxd_drv = 1'b1;
    drive_rx(8'h12, 1'b1, 1'b1);   // R9 parity error
    drive_rx(8'h34, 1'b0, 1'b0);   // R10 framing error
    wait_bit(); rxd_drv = 1'b1;
    drive_rx(8'h56, 1'b1, 1'b0);   // R10 both flags
    wait_bit(); rxd_drv = 1'b1;
    wait_quiet();
    cfg_par_en = 1'b0; cfg_par_odd = 1'b1;
    drive_rx(8'hC3, 1'b0, 1'b1);   // R5 odd ignored on receive
    wait_bit(); rxd_drv = 1'b1;
    wait_quiet();

    // R11 glitch: low for a few cycles, high again before midpoint
    seen0 = n_rx_seen;
    wait_bit(); rxd_drv = 1'b0;
    repeat (3) @(negedge clk);
    rxd_drv = 1'b1;
    repeat (14) wait_bit();
    check(n_rx_seen == seen0, "R11 glitch rejected", n_rx_seen - seen0, 0);
    drive_rx(8'hE7, 1'b0, 1'b1);   // R11 recovery
    wait_bit(); rxd_drv = 1'b1;
    wait_quiet();
    check(rxq.size() == 0 && txq.size() == 0, "R7 all items delivered",
          rxq.size() + txq.size(), 0);
    finish_run();
  end
endmodule